// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Arbiter

This block collects the request lines of a small microcontroller's interrupt sources. These are a reset source, a software trap, a clock time-base unit, four external lines, a serial-peripheral unit, two timers and a serial communication unit. There are also two reserved slots. The block picks the most urgent eligible request and presents its 16-bit vector address to the CPU core. The grant is captured in a register and is held until the core returns an acknowledge pulse. On that pulse the block sends a one-cycle clear strobe back to the granted source.

In the two low-power modes the block does not arbitrate. Instead it raises a wake request that depends only on its inputs, so the request is produced even when the clock is stopped. Each mode has its own set of sources that may wake the device. Source slots, the vector top address and the per-source masks are parameters.

Top module: `irq_vec_arbiter`

## Requirements
- R1: Source index sets priority: index 0 (reset) is highest, then 1 trap, 2 time-base, 3..6 external lines 0..3, 7 serial-peripheral unit, 8 timer A, 9 timer B, 10 serial unit. The lowest-numbered eligible request is granted.
- R2: While a grant is valid, `vec_o` equals 16'hFFFE minus twice the granted index, so reset gets FFFEh, the trap gets FFFCh, and the slots continue downward in steps of 2.
- R3: Slots 11 and 12 are reserved. A request on either of them is never granted and never wakes the device.
- R4: When `gmask_i` is 1, sources 2..12 are not eligible. Sources 0 and 1 cannot be masked.
- R5: A grant captured in run mode keeps `vld_o` high and keeps `idx_o` and `vec_o` unchanged until `ack_i` is sampled high, whatever the request lines do in the meantime.
- R6: When `ack_i` is high during a valid grant, `clr_o` is one-hot on the granted index in that same cycle. `vld_o` is low after the next edge, and a new grant can be captured at the edge after that. When no grant is valid, `ack_i` has no effect and `clr_o` stays 0.
- R7: With no valid grant, `vld_o` is 0, `idx_o` holds the idle code 13 and `vec_o` is 0.
- R8: In full-halt mode (`mode_i` = 2'b01), `wake_o` is the combinational OR of eligible pending requests on sources 0, 3, 4, 5, 6 and 7.
- R9: In active-halt mode (`mode_i` = 2'b10, and also 2'b11), `wake_o` is the combinational OR of eligible pending requests on sources 0 and 2 only.
- R10: In run mode (`mode_i` = 2'b00), `wake_o` is 0. In any other mode no new grant is captured.
- R11: While `rst_n` is low, `vld_o` is 0, `idx_o` is 13, `vec_o` is 0 and `clr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 13 | Pending request line per source slot |
| gmask_i | input | 1 | Global mask for maskable sources |
| mode_i | input | 2 | Power mode: 00 run, 01 full halt, 1x active halt |
| ack_i | input | 1 | Core acknowledge pulse for the current grant |
| vec_o | output | 16 | Vector address of the granted source |
| vld_o | output | 1 | Grant valid |
| idx_o | output | 4 | Granted source index, 13 when idle |
| clr_o | output | 13 | One-hot clear strobe to the acknowledged source |
| wake_o | output | 1 | Wake request in a low-power mode |

## Verification
The bench uses the default configuration: 13 slots, a vector top of FFFFh and the standard masks. At this size every one of the 8192 request patterns can be driven with the global mask both clear and set. Each of these patterns goes through a grant, an acknowledge, a full-halt wake check and an active-halt wake check. This covers every priority pairing, every masked and reserved slot, and every wake set combination. Directed sequences also cover holding a grant while the requests change, an acknowledge with no grant, and mode code 2'b11.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
   typedef enum logic [1:0] {
      PM_RUN   = 2'b00,
      PM_HALT  = 2'b01,
      PM_AHALT = 2'b10,
      PM_AHLT2 = 2'b11
   } pwr_mode_e;

   localparam int DEF_NSRC = 13;
   localparam logic [DEF_NSRC-1:0] DEF_USED  = 13'h07FF;
   localparam logic [DEF_NSRC-1:0] DEF_NMI   = 13'h0003;
   localparam logic [DEF_NSRC-1:0] DEF_HWAKE = 13'h00F9;
   localparam logic [DEF_NSRC-1:0] DEF_AWAKE = 13'h0005;
endpackage

// File: rtl/irq_src_gate.sv
`timescale 1ns/1ps
module irq_src_gate
   import irq_arb_pkg::*;
#(
   parameter int            NSRC      = DEF_NSRC,
   parameter logic [NSRC-1:0] USED_MASK = DEF_USED,
   parameter logic [NSRC-1:0] NMI_MASK  = DEF_NMI,
   parameter logic [NSRC-1:0] HWAKE     = DEF_HWAKE,
   parameter logic [NSRC-1:0] AWAKE     = DEF_AWAKE
) (
   input  logic [NSRC-1:0] req_i,
   input  logic            gmask_i,
   input  logic [1:0]      mode_i,
   output logic [NSRC-1:0] cand_o,
   output logic            wake_o
);
   logic [NSRC-1:0] pass;
   logic [NSRC-1:0] wsel;
   pwr_mode_e       pm;

   assign pm = pwr_mode_e'(mode_i);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (USED_MASK[i]) begin : g_live
         assign pass[i] = req_i[i] & (NMI_MASK[i] | ~gmask_i);
      end else begin : g_dead
         assign pass[i] = 1'b0;
      end
   end

   always_comb begin
      unique case (pm)
         PM_RUN:   wsel = '0;
         PM_HALT:  wsel = HWAKE;
         default:  wsel = AWAKE;
      endcase
   end

   assign wake_o = |(pass & wsel);
   assign cand_o = (pm == PM_RUN) ? pass : '0;
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
   parameter int NSRC = 13,
   parameter int IW   = $clog2(NSRC + 1)
) (
   input  logic [NSRC-1:0] cand_i,
   output logic            any_o,
   output logic [IW-1:0]   idx_o,
   output logic [NSRC-1:0] onehot_o
);
   always_comb begin
      logic found;
      found    = 1'b0;
      onehot_o = '0;
      idx_o    = IW'(NSRC);
      for (int i = 0; i < NSRC; i++) begin
         if (cand_i[i] && !found) begin
            onehot_o[i] = 1'b1;
            idx_o       = IW'(i);
         end
         found = found | cand_i[i];
      end
      any_o = found;
   end
endmodule

// File: rtl/irq_grant_hold.sv
`timescale 1ns/1ps
module irq_grant_hold #(
   parameter int NSRC = 13,
   parameter int IW   = $clog2(NSRC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            any_i,
   input  logic [IW-1:0]   idx_i,
   input  logic [NSRC-1:0] onehot_i,
   input  logic            ack_i,
   output logic            cap_o,
   output logic            vld_o,
   output logic [IW-1:0]   idx_o,
   output logic [NSRC-1:0] clr_o
);
   localparam logic [IW-1:0] IDLE = IW'(NSRC);

   logic            busy_q;
   logic [NSRC-1:0] sel_q;
   logic [IW-1:0]   idx_q;

   assign cap_o = ~busy_q & any_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sel_q  <= '0;
         idx_q  <= IDLE;
      end else if (cap_o) begin
         busy_q <= 1'b1;
         sel_q  <= onehot_i;
         idx_q  <= idx_i;
      end else if (busy_q && ack_i) begin
         busy_q <= 1'b0;
         sel_q  <= '0;
         idx_q  <= IDLE;
      end
   end

   assign vld_o = busy_q;
   assign idx_o = idx_q;
   assign clr_o = (busy_q && ack_i) ? sel_q : '0;

   assert_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && !ack_i) |=> (vld_o && $stable(idx_o)));
   assert_release_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && ack_i) |=> !vld_o);
   assert_clr_onehot_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));
   assert_clr_idle_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> (clr_o == '0));
endmodule

// File: rtl/irq_vec_arbiter.sv
`timescale 1ns/1ps
module irq_vec_arbiter
   import irq_arb_pkg::*;
#(
   parameter int              NSRC      = DEF_NSRC,
   parameter int              VW        = 16,
   parameter int              TOP_ADDR  = 'hFFFF,
   parameter logic [NSRC-1:0] USED_MASK = DEF_USED,
   parameter logic [NSRC-1:0] NMI_MASK  = DEF_NMI,
   parameter logic [NSRC-1:0] HWAKE     = DEF_HWAKE,
   parameter logic [NSRC-1:0] AWAKE     = DEF_AWAKE,
   parameter bit              REG_VEC   = 1'b1,
   localparam int             IW        = $clog2(NSRC + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_i,
   input  logic            gmask_i,
   input  logic [1:0]      mode_i,
   input  logic            ack_i,
   output logic [VW-1:0]   vec_o,
   output logic            vld_o,
   output logic [IW-1:0]   idx_o,
   output logic [NSRC-1:0] clr_o,
   output logic            wake_o
);
   localparam logic [IW-1:0] IDLE    = IW'(NSRC);
   localparam logic [VW-1:0] SLOT_HI = VW'(TOP_ADDR - 1);

   if (NSRC < 2 || NSRC > 64) begin : g_chk_n
      $error("irq_vec_arbiter: NSRC out of range");
   end
   if (TOP_ADDR + 1 < 2 * NSRC || TOP_ADDR >= (1 << VW)) begin : g_chk_top
      $error("irq_vec_arbiter: vector table does not fit");
   end

   logic [NSRC-1:0] cand;
   logic [NSRC-1:0] pick_oh;
   logic [IW-1:0]   pick_idx;
   logic            pick_any;
   logic            cap;

   irq_src_gate #(
      .NSRC(NSRC), .USED_MASK(USED_MASK), .NMI_MASK(NMI_MASK),
      .HWAKE(HWAKE), .AWAKE(AWAKE)
   ) i_gate (
      .req_i(req_i), .gmask_i(gmask_i), .mode_i(mode_i),
      .cand_o(cand), .wake_o(wake_o)
   );

   irq_prio_pick #(.NSRC(NSRC), .IW(IW)) i_pick (
      .cand_i(cand), .any_o(pick_any), .idx_o(pick_idx), .onehot_o(pick_oh)
   );

   irq_grant_hold #(.NSRC(NSRC), .IW(IW)) i_hold (
      .clk(clk), .rst_n(rst_n), .any_i(pick_any), .idx_i(pick_idx),
      .onehot_i(pick_oh), .ack_i(ack_i), .cap_o(cap), .vld_o(vld_o),
      .idx_o(idx_o), .clr_o(clr_o)
   );

   if (REG_VEC) begin : g_vec_reg
      logic [VW-1:0] vec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec_q <= '0;
         else if (cap)
            vec_q <= SLOT_HI - (VW'(pick_idx) << 1);
         else if (vld_o && ack_i)
            vec_q <= '0;
      end
      assign vec_o = vec_q;
   end else begin : g_vec_comb
      assign vec_o = vld_o ? (SLOT_HI - (VW'(idx_o) << 1)) : '0;
   end

   assert_reserved_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> USED_MASK[idx_o]);
   assert_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> (idx_o == IDLE && vec_o == '0));
   assert_wake_run_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |-> !wake_o);
   assert_nogrant_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_o) |-> ($past(mode_i) == 2'b00));
   assert_mask_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vld_o) && $past(gmask_i)) |-> NMI_MASK[idx_o]);
   assert_pending_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_o) |-> (($past(req_i) >> idx_o) & 1) != 0);
endmodule

// File: tb/test_irq_vec_arbiter.sv
`timescale 1ns/1ps
module test_irq_vec_arbiter;
   localparam int N = 13;
   localparam logic [12:0] USED  = 13'h07FF;
   localparam logic [12:0] NMI   = 13'h0003;
   localparam logic [12:0] HWAKE = 13'h00F9;
   localparam logic [12:0] AWAKE = 13'h0005;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] req = '0;
   logic        gm = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        ack = 1'b0;
   logic [15:0] vec;
   logic        vld;
   logic [3:0]  idx;
   logic [12:0] clr;
   logic        wake;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_vec_arbiter i_irq_vec_arbiter (
      .clk(clk), .rst_n(rst_n), .req_i(req), .gmask_i(gm), .mode_i(mode),
      .ack_i(ack), .vec_o(vec), .vld_o(vld), .idx_o(idx), .clr_o(clr),
      .wake_o(wake)
   );

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic logic [12:0] elig(input logic [12:0] p, input logic g);
      return p & USED & (g ? NMI : 13'h1FFF);
   endfunction

   function automatic int lowest(input logic [12:0] e);
      for (int i = 0; i < N; i++) if (e[i]) return i;
      return N;
   endfunction

   initial begin
      #1ms;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R11 reset state
      req = 13'h1FFF;
      repeat (3) @(negedge clk);
      chk("R11 vld", vld, 0);
      chk("R11 idx", idx, 13);
      chk("R11 vec", vec, 0);
      chk("R11 clr", clr, 0);
      req = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 ack with no grant is ignored
      ack = 1'b1; #1;
      chk("R6 idle ack clr", clr, 0);
      @(negedge clk);
      ack = 1'b0;
      chk("R7 idle vld", vld, 0);
      chk("R7 idle idx", idx, 13);

      // Sweep all patterns with mask clear and set
      for (int g = 0; g < 2; g++) begin
         for (int p = 0; p < 8192; p++) begin
            logic [12:0] e;
            int          ei;
            e  = elig(13'(p), g[0]);
            ei = lowest(e);
            @(negedge clk);
            req = 13'(p); gm = g[0]; mode = 2'b00; ack = 1'b0;
            #1 chk("R10 run wake", wake, 0);
            @(negedge clk);
            chk("R1 R4 R3 vld", vld, (ei < N) ? 1 : 0);
            chk("R1 R4 R3 R7 idx", idx, ei);
            chk("R2 R7 vec", vec, (ei < N) ? (16'hFFFE - 2 * ei) : 0);
            if (ei < N) begin
               ack = 1'b1;
               #1 chk("R6 clr", clr, 1 << ei);
            end
            @(negedge clk);
            ack = 1'b0; req = '0;
            chk("R6 release", vld, 0);
            mode = 2'b01; req = 13'(p);
            #1 chk("R8 halt wake", wake, ((e & HWAKE) != 0) ? 1 : 0);
            mode = 2'b10;
            #1 chk("R9 active halt wake", wake, ((e & AWAKE) != 0) ? 1 : 0);
            @(negedge clk);
            chk("R10 no grant in halt", vld, 0);
            mode = 2'b00; req = '0;
         end
      end

      // R9 mode code 11 behaves as active halt
      gm = 1'b0; mode = 2'b11; req = 13'h0008;
      #1 chk("R9 code11 ext0", wake, 0);
      req = 13'h0004;
      #1 chk("R9 code11 timebase", wake, 1);
      mode = 2'b00; req = '0;
      @(negedge clk);

      // R5 grant held while a higher request arrives
      req = 13'h0100;
      @(negedge clk);
      chk("R5 grant timer A", idx, 8);
      req = 13'h0101;
      @(negedge clk);
      chk("R5 held idx", idx, 8);
      chk("R5 held vec", vec, 16'hFFEE);
      @(negedge clk);
      chk("R5 held vld", vld, 1);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      chk("R6 gap cycle", vld, 0);
      @(negedge clk);
      chk("R6 regrant reset", idx, 0);
      chk("R6 regrant vec", vec, 16'hFFFE);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0; req = '0;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule